// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block sits beside the data path of a NAND flash controller and builds a single-error-correcting Hamming code from the bytes that pass through it. Each 256-byte segment of a page gets its own accumulator. An accumulator keeps sixteen line-parity bits, which are two per byte-address bit and formed from the parity of each byte. It also keeps the running XOR of all the bytes, and six column-parity bits are derived from that XOR. A 512-byte page uses two accumulators and yields six code bytes.

Software drives the engine through a 2-bit mode input. To arm the engine it applies clear, then off, then accumulate. To fetch the code it applies off, then read-out, then off. In read-out mode each data-register read strobe moves an internal pointer forward, and the code byte at that pointer sits on the output. For each segment the bytes come out in the order byte 1, byte 0, byte 2. Software compares the stored code with a freshly computed code to correct data, and that step is outside this block.

Top module: `nand_hecc_engine`

## Requirements
- R1: Mode 2'b11 clears every accumulator, the byte counter and the read-out pointer. After a clear, every code byte reads 0xFF.
- R2: In mode 2'b00, data bytes are ignored and the stored code does not change.
- R3: In mode 2'b01, each byte with byte_vld_i high is accumulated. Bytes 0..255 after a clear go to segment 0 and bytes 256..511 go to segment 1.
- R4: Code byte 0 is the inverse of line parities LP7..LP0 (bit 7 = LP7). Code byte 1 is the inverse of LP15..LP8. LP(2i) is the XOR of the bit-parities of bytes whose segment address has bit i = 0, and LP(2i+1) covers the bytes where that bit is 1.
- R5: Code byte 2 holds the inverse of CP5..CP0 in bits 7..2, and bits 1..0 read 1. CP(2j) is the XOR over all bytes of the data bits whose bit index has bit j = 0, and CP(2j+1) covers the bits where that index bit is 1.
- R6: A page of all-0xFF data gives all-0xFF code bytes.
- R7: In mode 2'b10, code_o shows the byte at the pointer, and each code_rd_i cycle advances the pointer. The order is seg0 byte1, seg0 byte0, seg0 byte2, seg1 byte1, seg1 byte0, seg1 byte2.
- R8: After the last code byte, the next read returns to the first.
- R9: In any mode other than 2'b10, the pointer returns to the first code byte.
- R10: Bytes beyond 512 accumulated since a clear are ignored.
- R11: If a code is taken after flipping one data bit, the XOR with the original code flips exactly LP(2i + A[i]) for each address bit i and CP(2j + B[j]) for each bit-index bit j, where A is the byte address and B is the bit index. The other segment's code is unchanged.
- R12: Asserting rst_n low has the same effect on state as a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 off, 01 accumulate, 10 read-out, 11 clear |
| byte_vld_i | input | 1 | A data byte moves on the data path this cycle |
| byte_i | input | 8 | Data byte |
| code_rd_i | input | 1 | Data-register read strobe during read-out |
| code_o | output | 8 | Code byte at the read-out pointer |

## Verification
The bench runs several kinds of page through the engine. An erased all-0xFF page must give all-0xFF codes. A pseudo-random page exercises every line and column term in both segments and so catches any crossed parity index or swapped byte order. Bytes fed while the mode is off, and bytes fed past the 512-byte limit, must leave the code unchanged, which separates hold and saturation from accumulation. A page with one flipped bit in the second segment is compared against the clean page: the syndrome must name that byte's address and bit index, and the first segment's code must stay the same.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_ACC   = 2'b01,
    MODE_READ  = 2'b10,
    MODE_CLEAR = 2'b11
  } hecc_mode_e;

  localparam int SEG_BYTES  = 256;
  localparam int ADDR_W     = $clog2(SEG_BYTES);
  localparam int LINE_BITS  = 2 * ADDR_W;
  localparam int COL_PAIRS  = 3;
  localparam int CODE_BYTES = 3;

  // read-out position k within a segment selects this stored code byte
  function automatic int out_order(input int k);
    case (k)
      0:       return 1;
      1:       return 0;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/hecc_seg_acc.sv
module hecc_seg_acc
  import hecc_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr_i,
  input  logic                             en_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [7:0]                       byte_i,
  output logic [CODE_BYTES-1:0][7:0]       code_o
);
  logic [ADDR_W-1:0] lo_q, lo_d;   // line parity where address bit = 0
  logic [ADDR_W-1:0] hi_q, hi_d;   // line parity where address bit = 1
  logic [7:0]        col_q, col_d; // running xor of bytes
  logic              upd;
  logic              bpar;

  assign upd  = clr_i | en_i;
  assign bpar = ^byte_i;

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    col_d = col_q;
    if (clr_i) begin
      lo_d  = '0;
      hi_d  = '0;
      col_d = '0;
    end else if (en_i) begin
      for (int i = 0; i < ADDR_W; i++) begin
        if (addr_i[i]) hi_d[i] = hi_q[i] ^ bpar;
        else           lo_d[i] = lo_q[i] ^ bpar;
      end
      col_d = col_q ^ byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      col_q <= '0;
    end else if (upd) begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      col_q <= col_d;
    end
  end

  // line parity vector, index 2i+v
  logic [LINE_BITS-1:0] lp;
  logic [2*COL_PAIRS-1:0] cp;

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      lp[2*i]   = lo_q[i];
      lp[2*i+1] = hi_q[i];
    end
    cp = '0;
    for (int j = 0; j < COL_PAIRS; j++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> j) & 1) == 1) cp[2*j+1] = cp[2*j+1] ^ col_q[b];
        else                     cp[2*j]   = cp[2*j]   ^ col_q[b];
      end
    end
  end

  assign code_o[0] = ~lp[7:0];
  assign code_o[1] = ~lp[15:8];
  assign code_o[2] = ~{cp, 2'b00};

  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i && !en_i |=> $stable({lo_q, hi_q, col_q})); // R2

  AST_LANE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (code_o[0] == 8'hFF && code_o[1] == 8'hFF && code_o[2] == 8'hFF)); // R1

  AST_LINE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !clr_i && bpar |=> $countones({lo_q, hi_q} ^ $past({lo_q, hi_q})) == ADDR_W); // R4
endmodule

// File: rtl/hecc_code_seq.sv
module hecc_code_seq
  import hecc_pkg::*;
#(
  parameter int NUM_SEG = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    read_mode_i,
  input  logic                                    rd_i,
  input  logic [NUM_SEG-1:0][CODE_BYTES-1:0][7:0] codes_i,
  output logic [7:0]                              byte_o
);
  localparam int NUM_OUT = NUM_SEG * CODE_BYTES;
  localparam int PTR_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_OUT - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  assign ptr_en = !read_mode_i || rd_i;

  always_comb begin
    ptr_d = ptr_q;
    if (!read_mode_i)       ptr_d = '0;
    else if (rd_i)          ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_comb begin
    byte_o = 8'h00;
    for (int s = 0; s < NUM_SEG; s++) begin
      for (int k = 0; k < CODE_BYTES; k++) begin
        if (ptr_q == PTR_W'(s * CODE_BYTES + k)) byte_o = codes_i[s][out_order(k)];
      end
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST); // R8

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    read_mode_i && rd_i && ptr_q == LAST |=> ptr_q == '0); // R8

  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !read_mode_i |=> ptr_q == '0); // R9

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    read_mode_i && !rd_i |=> $stable(ptr_q)); // R7
endmodule

// File: rtl/nand_hecc_engine.sv
module nand_hecc_engine
  import hecc_pkg::*;
#(
  parameter int NUM_SEG = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       code_rd_i,
  output logic [7:0] code_o
);
  localparam int TOTAL = NUM_SEG * SEG_BYTES;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam int HI_W  = CNT_W - ADDR_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  hecc_mode_e mode;
  assign mode = hecc_mode_e'(mode_i);

  logic clr, take;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign clr    = (mode == MODE_CLEAR);
  assign take   = (mode == MODE_ACC) && byte_vld_i && (cnt_q < CNT_W'(TOTAL));
  assign cnt_en = clr || take;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (take) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  logic [NUM_SEG-1:0][CODE_BYTES-1:0][7:0] codes;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic seg_en;
    assign seg_en = take && (cnt_q[CNT_W-1:ADDR_W] == HI_W'(g));
    hecc_seg_acc u_acc (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .clr_i  (clr),
      .en_i   (seg_en),
      .addr_i (cnt_q[ADDR_W-1:0]),
      .byte_i (byte_i),
      .code_o (codes[g])
    );
  end

  hecc_code_seq #(.NUM_SEG(NUM_SEG)) u_seq (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .read_mode_i (mode == MODE_READ),
    .rd_i        (code_rd_i),
    .codes_i     (codes),
    .byte_o      (code_o)
  );

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_s_n)
    cnt_q <= CNT_W'(TOTAL)); // R10

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_s_n)
    clr |=> cnt_q == '0); // R1

  AST_CNT_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    !clr && cnt_q == CNT_W'(TOTAL) |=> cnt_q == CNT_W'(TOTAL)); // R10

  AST_CNT_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    mode == MODE_OFF |=> $stable(cnt_q)); // R2
endmodule

// File: tb/sim_nand_hecc_engine.sv
`timescale 1ns/1ps
module sim_nand_hecc_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       vld = 1'b0;
  logic [7:0] dat = 8'h00;
  logic       rd = 1'b0;
  logic [7:0] code;

  always #4 clk = ~clk;

  nand_hecc_engine u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .byte_vld_i(vld),
    .byte_i(dat), .code_rd_i(rd), .code_o(code)
  );

  typedef struct { logic [7:0] v; string req; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] cap[$];
  logic [7:0] pg [0:511];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // monitor: compare every read-out byte against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd && mode == 2'b10) begin
      cap.push_back(code);
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R7: unexpected code byte got %02h expected none", code);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (code !== e.v) begin
          n_bad++;
          $display("FAIL %s: code byte got %02h expected %02h", e.req, code, e.v);
        end
      end
    end
  end

  function automatic logic [23:0] ref_code(int base);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int a = 0; a < 256; a++) begin
      logic p;
      p = ^pg[base + a];
      for (int i = 0; i < 8; i++) lp[2*i + ((a >> i) & 1)] ^= p;
      for (int b = 0; b < 8; b++)
        if (pg[base + a][b])
          for (int j = 0; j < 3; j++) cp[2*j + ((b >> j) & 1)] ^= 1'b1;
    end
    return {~{cp, 2'b00}, ~lp[15:8], ~lp[7:0]};
  endfunction

  task automatic push_page(string req, int nbytes);
    logic [23:0] c0, c1;
    logic [7:0]  seq [0:5];
    c0 = ref_code(0);
    c1 = ref_code(256);
    seq[0] = c0[15:8]; seq[1] = c0[7:0]; seq[2] = c0[23:16];
    seq[3] = c1[15:8]; seq[4] = c1[7:0]; seq[5] = c1[23:16];
    for (int k = 0; k < nbytes; k++) begin
      exp_t e;
      e.v = seq[k % 6];
      e.req = req;
      exp_q.push_back(e);
    end
  endtask

  task automatic push_ff(string req, int n);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.v = 8'hFF;
      e.req = req;
      exp_q.push_back(e);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic arm();
    mode = 2'b11; step();
    mode = 2'b00; step();
  endtask

  task automatic feed(int start, int n, logic [1:0] m);
    mode = m;
    for (int k = 0; k < n; k++) begin
      vld = 1'b1;
      dat = pg[(start + k) % 512];
      step();
    end
    vld = 1'b0;
    mode = 2'b00;
    step();
  endtask

  task automatic read_n(int n);
    mode = 2'b10;
    rd = 1'b1;
    repeat (n) step();
    rd = 1'b0;
    mode = 2'b00;
    step();
  endtask

  task automatic chk(string req, logic [15:0] got, logic [15:0] expv);
    n_cmp++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: syndrome got %04h expected %04h", req, got, expv);
    end
  endtask

  task automatic fill_lfsr(logic [15:0] seed);
    logic [15:0] s = seed;
    for (int k = 0; k < 512; k++) begin
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
      pg[k] = s[7:0] ^ s[15:8];
    end
  endtask

  initial begin
    logic [7:0] orig [0:5];
    logic [7:0] flip [0:5];
    logic [15:0] exp_lp;
    logic [5:0]  exp_cp;
    int A, B;

    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R12 / R1: state after reset is all 0xFF
    push_ff("R12", 6);
    read_n(6);

    // R6: erased page
    for (int k = 0; k < 512; k++) pg[k] = 8'hFF;
    arm();
    feed(0, 512, 2'b01);
    push_ff("R6", 6);
    read_n(6);

    // R3 R4 R5 R7 R8: random page, read seven bytes to see the wrap
    fill_lfsr(16'hACE1);
    arm();
    feed(0, 512, 2'b01);
    cap.delete();
    push_page("R4 R5 R7 R8", 7);
    read_n(7);
    for (int k = 0; k < 6; k++) orig[k] = cap[k];

    // R2: bytes in off mode are ignored
    feed(17, 40, 2'b00);
    push_page("R2", 6);
    read_n(6);

    // R10: bytes past the page limit are ignored
    feed(3, 30, 2'b01);
    push_page("R10", 6);
    read_n(6);

    // R9: pointer restarts after leaving read mode
    push_page("R9", 2);
    read_n(2);
    push_page("R9", 3);
    read_n(3);

    // R1: clear in the middle of use
    arm();
    push_ff("R1", 6);
    read_n(6);

    // R3 R11: one flipped bit in the second segment
    A = 8'hA5;
    B = 6;
    pg[256 + A] = pg[256 + A] ^ (8'h01 << B);
    arm();
    feed(0, 512, 2'b01);
    cap.delete();
    push_page("R3", 6);
    read_n(6);
    for (int k = 0; k < 6; k++) flip[k] = cap[k];
    exp_lp = '0;
    for (int i = 0; i < 8; i++) exp_lp[2*i + ((A >> i) & 1)] = 1'b1;
    exp_cp = '0;
    for (int j = 0; j < 3; j++) exp_cp[2*j + ((B >> j) & 1)] = 1'b1;
    chk("R11", {orig[3] ^ flip[3], orig[4] ^ flip[4]}, exp_lp);
    chk("R11", {10'h0, (orig[5] ^ flip[5]) >> 2}, {10'h0, exp_cp});
    chk("R11", {orig[0] ^ flip[0], orig[1] ^ flip[1]}, 16'h0000);
    chk("R11", {8'h00, orig[2] ^ flip[2]}, 16'h0000);

    if (exp_q.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R7: %0d expected bytes never read got 0 expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL R7: watchdog expired got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule